// File: doc/BRIEF.md
# UART Receive Address Match Filter

This block stands between the character deserializer of a UART receiver and the receive data buffer behind it. For each received character it decides whether the character is written into the buffer. It can also let only the traffic addressed to this node through. Two match slots each hold a programmable character value and have their own enable bit. A two-bit mode field selects how an address is recognised.

In marked mode, an address is a frame whose marker bit (the bit just before the stop bit) is one. In idle mode, the first character after an idle-line pulse is the address. An address that equals an enabled slot opens an acceptance window, and the address itself is written. In marked mode the window is closed by the next marked frame. In idle mode it is closed by the next idle line. The block drives a write strobe with the character, and a full flag that software clears with a read acknowledge. Baud timing, bit sampling and idle detection are done upstream.

Top module: `uart_addr_filter`

## Requirements
- R1: When both slot enables are 0, every received character is written to the buffer, whatever the mode and marker bit.
- R2: Mode values 2'b10 and 2'b11 are reserved and behave as pass-through: every character is written, even when enables are set.
- R3: With only one slot enabled, an address is compared only with that slot's value. An address equal to the disabled slot's value is rejected.
- R4: With both slots enabled, an address equal to either slot value is accepted.
- R5: Marked mode (mode 2'b00): a marked frame that matches no enabled slot is not written. Every following unmarked frame is also not written, until a marked frame that matches.
- R6: Marked mode: a matching marked frame is written. The following unmarked frames are written until the next marked frame. Idle pulses have no effect in this mode.
- R7: Idle mode (mode 2'b01): the first character after an idle pulse is the address. If it matches, it is written and so is every later character until the next idle pulse.
- R8: Idle mode: an address that does not match, and every character after it, is not written until the next idle pulse. After reset, characters are discarded until the first idle pulse.
- R9: A change of either enable or of the mode closes the acceptance window and cancels a pending idle-mode address, from the cycle of the change onward.
- R10: The full flag rises together with every write strobe. It is cleared by rd_ack in the cycle after the acknowledge, unless a write happens at the same edge, in which case it stays set.
- R11: After reset, buf_wr and rx_full are 0. A character accepted while rx_valid is high appears on buf_wr and buf_data exactly one cycle later. buf_wr is never high without a preceding rx_valid.
- R12: An idle pulse in the same cycle as a character is applied after that character: the character is judged by the state before the pulse, and the next character is the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_match_en | input | 2 | Enable of each match slot (bit 0 = slot A, bit 1 = slot B) |
| cfg_match_val | input | 2*CHAR_W | Slot values, slot A in the low CHAR_W bits |
| cfg_mode | input | 2 | 00 marked, 01 idle, 10/11 pass-through |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_char | input | CHAR_W | Received character (full configured width) |
| rx_mark | input | 1 | Marker bit of the frame (bit before stop) |
| idle_pulse | input | 1 | One-cycle pulse: idle line detected |
| rd_ack | input | 1 | Buffer read acknowledge, clears the full flag |
| buf_wr | output | 1 | Buffer write strobe |
| buf_data | output | CHAR_W | Character to write |
| rx_full | output | 1 | Receive-data-full flag |

## Verification
Each accept or reject decision shows up on buf_wr and buf_data at the first rising edge after the rx_valid cycle, and rx_full changes at that same edge. The clearing by rd_ack also lands one edge later. A configuration change or an idle pulse affects the character of the same cycle (R9) or the next character (R12), not some later one. The bench advances its behavioural model at each rising edge from the inputs held there. It compares all three outputs at the following falling edge, so every result is sampled exactly one register stage after its cause. Directed checks sample at that same falling edge, against values worked out by hand.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    localparam int N_SLOT = 2;

    typedef enum logic [1:0] {
        MODE_MARK = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } filt_mode_e;

    typedef struct packed {
        logic [N_SLOT-1:0] en;
        filt_mode_e        mode;
    } filt_cfg_t;

    typedef struct packed {
        logic write;
        logic win;
        logic await_addr;
    } filt_step_t;

    function automatic logic filt_active(input filt_cfg_t c);
        return (|c.en) && !c.mode[1];
    endfunction

endpackage

// File: rtl/uaf_slot_cmp.sv
module uaf_slot_cmp
    import uaf_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic [N_SLOT-1:0]        slot_en,
    input  logic [N_SLOT*CHAR_W-1:0] slot_val,
    input  logic [CHAR_W-1:0]        chr,
    output logic                     any_hit
);
    logic [N_SLOT-1:0] hit_vec;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        assign hit_vec[s] = slot_en[s] && (chr == slot_val[s*CHAR_W +: CHAR_W]);
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/uaf_window.sv
module uaf_window
    import uaf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  filt_cfg_t cfg,
    input  logic      rx_valid,
    input  logic      rx_mark,
    input  logic      hit,
    input  logic      idle_pulse,
    output logic      write_go
);
    filt_cfg_t  cfg_q;
    logic       win_q;
    logic       await_q;
    logic       cfg_chg;
    logic       active;
    filt_step_t cur;
    filt_step_t nxt;

    assign cfg_chg = (cfg != cfg_q);
    assign active  = filt_active(cfg);

    always_comb begin
        cur.write      = 1'b0;
        cur.win        = win_q   && !cfg_chg;
        cur.await_addr = await_q && !cfg_chg;
        nxt            = cur;
        if (rx_valid) begin
            if (!active) begin
                nxt.write = 1'b1;
            end else begin
                case (cfg.mode)
                    MODE_MARK: begin
                        if (rx_mark) begin
                            nxt.write = hit;
                            nxt.win   = hit;
                        end else begin
                            nxt.write = cur.win;
                        end
                    end
                    MODE_IDLE: begin
                        if (cur.await_addr) begin
                            nxt.write      = hit;
                            nxt.win        = hit;
                            nxt.await_addr = 1'b0;
                        end else begin
                            nxt.write = cur.win;
                        end
                    end
                    default: nxt.write = 1'b1;
                endcase
            end
        end
        if (idle_pulse && active && cfg.mode == MODE_IDLE) begin
            nxt.win        = 1'b0;
            nxt.await_addr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= cfg;
            win_q   <= 1'b0;
            await_q <= 1'b0;
        end else begin
            cfg_q   <= cfg;
            win_q   <= nxt.win;
            await_q <= nxt.await_addr;
        end
    end

    assign write_go = nxt.write;
endmodule

// File: rtl/uaf_outreg.sv
module uaf_outreg #(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              write_go,
    input  logic [CHAR_W-1:0] chr,
    input  logic              rd_ack,
    output logic              buf_wr,
    output logic [CHAR_W-1:0] buf_data,
    output logic              rx_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_wr   <= 1'b0;
            buf_data <= '0;
            rx_full  <= 1'b0;
        end else begin
            buf_wr  <= write_go;
            rx_full <= write_go || (rx_full && !rd_ack);
            if (write_go) begin
                buf_data <= chr;
            end
        end
    end
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
    import uaf_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               cfg_match_en,
    input  logic [2*CHAR_W-1:0]      cfg_match_val,
    input  logic [1:0]               cfg_mode,
    input  logic                     rx_valid,
    input  logic [CHAR_W-1:0]        rx_char,
    input  logic                     rx_mark,
    input  logic                     idle_pulse,
    input  logic                     rd_ack,
    output logic                     buf_wr,
    output logic [CHAR_W-1:0]        buf_data,
    output logic                     rx_full
);
    filt_cfg_t cfg;
    logic      hit;
    logic      write_go;

    assign cfg.en   = cfg_match_en;
    assign cfg.mode = filt_mode_e'(cfg_mode);

    uaf_slot_cmp #(.CHAR_W(CHAR_W)) u_cmp (
        .slot_en  (cfg_match_en),
        .slot_val (cfg_match_val),
        .chr      (rx_char),
        .any_hit  (hit)
    );

    uaf_window u_win (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .rx_valid   (rx_valid),
        .rx_mark    (rx_mark),
        .hit        (hit),
        .idle_pulse (idle_pulse),
        .write_go   (write_go)
    );

    uaf_outreg #(.CHAR_W(CHAR_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .write_go (write_go),
        .chr      (rx_char),
        .rd_ack   (rd_ack),
        .buf_wr   (buf_wr),
        .buf_data (buf_data),
        .rx_full  (rx_full)
    );
endmodule

// File: rtl/uaf_checker.sv
module uaf_checker #(
    parameter int CHAR_W = 9
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          cfg_match_en,
    input logic [2*CHAR_W-1:0] cfg_match_val,
    input logic [1:0]          cfg_mode,
    input logic                rx_valid,
    input logic [CHAR_W-1:0]   rx_char,
    input logic                rx_mark,
    input logic                rd_ack,
    input logic                buf_wr,
    input logic [CHAR_W-1:0]   buf_data,
    input logic                rx_full
);
    logic chk_hit;
    assign chk_hit = (cfg_match_en[0] && rx_char == cfg_match_val[CHAR_W-1:0]) ||
                     (cfg_match_en[1] && rx_char == cfg_match_val[2*CHAR_W-1:CHAR_W]);

    p_wr_cause_r11: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> $past(rx_valid));

    p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_match_en == 2'b00) |=> (buf_wr && buf_data == $past(rx_char)));

    p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_mode[1]) |=> buf_wr);

    p_marked_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_match_en != 2'b00 && cfg_mode == 2'b00 && rx_mark && !chk_hit) |=> !buf_wr);

    p_marked_hit_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_match_en != 2'b00 && cfg_mode == 2'b00 && rx_mark && chk_hit) |=> buf_wr);

    p_cfg_change_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_mark && cfg_match_en != 2'b00 && cfg_mode == 2'b00 &&
         (cfg_match_en != $past(cfg_match_en) || cfg_mode != $past(cfg_mode))) |=> !buf_wr);

    p_full_on_write_r10: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> rx_full);

    p_full_ack_r10: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> (!rx_full || buf_wr));
endmodule

bind uart_addr_filter uaf_checker #(.CHAR_W(CHAR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_match_en  (cfg_match_en),
    .cfg_match_val (cfg_match_val),
    .cfg_mode      (cfg_mode),
    .rx_valid      (rx_valid),
    .rx_char       (rx_char),
    .rx_mark       (rx_mark),
    .rd_ack        (rd_ack),
    .buf_wr        (buf_wr),
    .buf_data      (buf_data),
    .rx_full       (rx_full)
);

// File: tb/uart_addr_filter_tb.sv
module uart_addr_filter_tb;
    localparam int W = 9;
    localparam logic [W-1:0] VAL_A = 9'h1A5;
    localparam logic [W-1:0] VAL_B = 9'h033;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cfg_match_en = 2'b00;
    logic [2*W-1:0] cfg_match_val = {VAL_B, VAL_A};
    logic [1:0]   cfg_mode = 2'b00;
    logic         rx_valid = 1'b0;
    logic [W-1:0] rx_char = '0;
    logic         rx_mark = 1'b0;
    logic         idle_pulse = 1'b0;
    logic         rd_ack = 1'b0;
    logic         buf_wr;
    logic [W-1:0] buf_data;
    logic         rx_full;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R11";

    always #5 clk = ~clk;

    uart_addr_filter #(.CHAR_W(W)) u_dut (
        .clk(clk), .rst(rst), .cfg_match_en(cfg_match_en), .cfg_match_val(cfg_match_val),
        .cfg_mode(cfg_mode), .rx_valid(rx_valid), .rx_char(rx_char), .rx_mark(rx_mark),
        .idle_pulse(idle_pulse), .rd_ack(rd_ack), .buf_wr(buf_wr), .buf_data(buf_data),
        .rx_full(rx_full)
    );

    // behavioural reference model
    bit         m_win, m_await, e_wr, e_full;
    logic [W-1:0] e_data;
    logic [1:0] p_en, p_mode;

    always @(posedge clk) begin
        if (rst) begin
            m_win = 0; m_await = 0; e_wr = 0; e_full = 0; e_data = '0;
            p_en = cfg_match_en; p_mode = cfg_mode;
        end else begin
            bit changed, filt, match, acc;
            changed = (p_en != cfg_match_en) || (p_mode != cfg_mode);
            if (changed) begin m_win = 0; m_await = 0; end
            filt  = (cfg_match_en != 0) && (cfg_mode < 2);
            match = (cfg_match_en[0] && rx_char == VAL_A) ||
                    (cfg_match_en[1] && rx_char == VAL_B);
            acc = 0;
            if (rx_valid) begin
                if (!filt) acc = 1;
                else if (cfg_mode == 0) begin
                    if (rx_mark) begin acc = match; m_win = match; end
                    else acc = m_win;
                end else begin
                    if (m_await) begin acc = match; m_win = match; m_await = 0; end
                    else acc = m_win;
                end
            end
            if (idle_pulse && filt && cfg_mode == 1) begin m_win = 0; m_await = 1; end
            e_wr = acc;
            if (acc) e_data = rx_char;
            e_full = acc || (e_full && !rd_ack);
            p_en = cfg_match_en; p_mode = cfg_mode;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(buf_wr == e_wr, tag, "model buf_wr", buf_wr, e_wr);
            chk(rx_full == e_full, tag, "model rx_full", rx_full, e_full);
            if (e_wr) chk(buf_data == e_data, tag, "model buf_data", buf_data, e_data);
        end
    end

    task automatic send(input logic [W-1:0] c, input bit m, input bit exp_wr, input string req);
        tag = req;
        @(negedge clk);
        rx_valid = 1; rx_char = c; rx_mark = m;
        @(negedge clk);
        rx_valid = 0; rx_mark = 0;
        chk(buf_wr == exp_wr, req, "buf_wr", buf_wr, exp_wr);
        if (exp_wr) chk(buf_data == c, req, "buf_data", buf_data, c);
    endtask

    task automatic idle();
        @(negedge clk); idle_pulse = 1;
        @(negedge clk); idle_pulse = 0;
    endtask

    task automatic set_cfg(input logic [1:0] en, input logic [1:0] md, input string req);
        tag = req;
        @(negedge clk); cfg_match_en = en; cfg_mode = md;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(buf_wr == 0, "R11", "reset buf_wr", buf_wr, 0);
        chk(rx_full == 0, "R11", "reset rx_full", rx_full, 0);

        // R1 transparent
        send(9'h011, 0, 1, "R1");
        send(9'h1FF, 1, 1, "R1");
        send(9'h100, 0, 1, "R1");

        // R2 reserved modes
        set_cfg(2'b11, 2'b10, "R2");
        send(9'h077, 1, 1, "R2");
        set_cfg(2'b11, 2'b11, "R2");
        send(9'h078, 0, 1, "R2");

        // R3/R5/R6 marked mode, slot A only
        set_cfg(2'b01, 2'b00, "R3");
        send(VAL_B, 1, 0, "R3");
        send(9'h011, 0, 0, "R5");
        send(VAL_A, 1, 1, "R6");
        send(9'h022, 0, 1, "R6");
        idle();
        send(9'h100, 0, 1, "R6");
        send(9'h0FF, 1, 0, "R5");
        send(9'h023, 0, 0, "R5");

        // R4 both slots
        set_cfg(2'b11, 2'b00, "R4");
        send(VAL_B, 1, 1, "R4");
        send(9'h024, 0, 1, "R4");
        send(VAL_A, 1, 1, "R4");

        // R7/R8 idle mode, slot B only
        set_cfg(2'b10, 2'b01, "R8");
        send(VAL_B, 0, 0, "R8");
        idle();
        send(VAL_B, 0, 1, "R7");
        send(9'h031, 0, 1, "R7");
        send(9'h132, 1, 1, "R7");
        idle();
        send(VAL_A, 0, 0, "R3");
        send(9'h033, 0, 0, "R8");
        idle();
        send(VAL_B, 0, 1, "R7");

        // R12 idle pulse together with a data character
        tag = "R12";
        @(negedge clk);
        rx_valid = 1; rx_char = 9'h055; idle_pulse = 1;
        @(negedge clk);
        rx_valid = 0; idle_pulse = 0;
        chk(buf_wr == 1, "R12", "buf_wr same-cycle idle", buf_wr, 1);
        send(9'h044, 0, 0, "R12");

        // R9 configuration change closes window
        set_cfg(2'b01, 2'b00, "R9");
        send(VAL_A, 1, 1, "R9");
        send(9'h012, 0, 1, "R9");
        tag = "R9";
        @(negedge clk);
        cfg_match_en = 2'b11; rx_valid = 1; rx_char = 9'h013; rx_mark = 0;
        @(negedge clk);
        rx_valid = 0;
        chk(buf_wr == 0, "R9", "buf_wr after cfg change", buf_wr, 0);
        send(9'h014, 0, 0, "R9");

        // R10 full flag
        tag = "R10";
        chk(rx_full == 1, "R10", "rx_full held", rx_full, 1);
        @(negedge clk); rd_ack = 1;
        @(negedge clk); rd_ack = 0;
        chk(rx_full == 0, "R10", "rx_full after ack", rx_full, 0);
        set_cfg(2'b00, 2'b00, "R10");
        @(negedge clk);
        rx_valid = 1; rx_char = 9'h0AA; rd_ack = 1;
        @(negedge clk);
        rx_valid = 0; rd_ack = 0;
        chk(rx_full == 1, "R10", "write beats ack", rx_full, 1);
        chk(buf_wr == 1, "R10", "buf_wr with ack", buf_wr, 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule